// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers single-cycle event pulses from peripherals and pins into a group of 32-bit pending sets and reports them to a processor on two separate interrupt lines. A fixed group of sources is treated as urgent. Each of these carries a priority level from 1 to 15. They drive the high line, and the block reports a 4-bit vector holding the most urgent level that is pending and enabled. Every other source drives the low line, and each of those sources is enabled by its own bit.

Software works the block through a small word-addressed register bus. Reads are combinational and writes take effect on the next clock edge. Each set has a read-only pending register, a write-one-to-clear register and an enable register. A control word holds a 16-bit mask with one bit per level and a master enable. A summary word gives the vector and two pending flags. The rising and falling edges of one pin are separate sources. A source number is formed as set×32 + bit. Source 0 is not valid and never latches.

Top module: `icu_two_level`

## Requirements
- R1: After reset, every pending bit, every enable bit, the level mask and the master enable read 0, and both interrupt lines are low.
- R2: A pulse on a source sets its pending bit on the next clock edge. The bit then stays set, with no further pulses, until software clears it.
- R3: Writing the clear register of set s (word address 0x08+s) clears each pending bit written as 1 and leaves the bits written as 0 unchanged. A pulse that arrives in the same cycle as a clear of that bit leaves the bit set.
- R4: `irq_low` is high when the master enable is set and some low-path source is pending with its bit set in the enable register of its set (word address 0x10+s).
- R5: Enable-register bits of urgent sources have no effect on `irq_low`. An urgent source never drives the low line.
- R6: An urgent pending source counts toward `irq_high` and the vector only when bit n of the level mask (control bits [15:0]) is set for its level n.
- R7: The vector (summary bits [3:0]) holds the highest level among the pending urgent sources whose level is enabled. It is 0 when no such source exists. When several sources share the top level, it still reports that level.
- R8: The level table is fixed. Set 5 bits 25 and 24 are level 15, bit 30 is level 14, bit 29 is level 13, and bits 7 and 0 are level 1. Set 1 bit 18 is level 4, bit 17 is level 3 and bit 27 is level 2. Every other source is a low-path source.
- R9: Summary bit 8 shows a pending enabled urgent source and summary bit 9 shows a pending enabled low source. Both flags are independent of the master enable.
- R10: Neither interrupt line asserts unless the master enable (control bit 16) is set.
- R11: Source 0 (set 0 bit 0) never sets its pending bit.
- R12: Word addresses: pending set s at 0x00+s, clear at 0x08+s (reads 0), enable at 0x10+s, control at 0x18, summary at 0x19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | N_SETS*32 | Synchronized event pulses, bit = set×32 + bit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_high | output | 1 | Urgent, prioritized interrupt line |
| irq_low | output | 1 | Flat, per-bit-enabled interrupt line |

## Verification
A pulse or a register write presented before a rising edge shows up in the pending registers, the summary word and both interrupt lines directly after that edge. The register path adds no further delay, because the lines and the read data are combinational from the registered state. The bench drives every input on the falling edge. It therefore reads and samples results on the next falling edge, one edge after the stimulus, with the bus address settled 1 ns before sampling. Hold checks wait several extra cycles before they look again.

// File: rtl/icu_pkg.sv
// Package: shared constants and the fixed urgency table of the controller.
// Assumes sets are 32 bits wide and levels fit in four bits.
package icu_pkg;
    localparam int LVL_W   = 4;
    localparam int NUM_LVL = 1 << LVL_W;

    // Fixed urgency level of a source; 0 means the source uses the low path.
    function automatic logic [LVL_W-1:0] level_of(input int unsigned set_i,
                                                  input int unsigned bit_i);
        logic [LVL_W-1:0] lv;
        lv = '0;
        if (set_i == 5) begin
            case (bit_i)
                25, 24:  lv = 4'd15;
                30:      lv = 4'd14;
                29:      lv = 4'd13;
                7, 0:    lv = 4'd1;
                default: lv = '0;
            endcase
        end else if (set_i == 1) begin
            case (bit_i)
                18:      lv = 4'd4;
                17:      lv = 4'd3;
                27:      lv = 4'd2;
                default: lv = '0;
            endcase
        end
        return lv;
    endfunction
endpackage

// File: rtl/icu_status_bank.sv
// Module: pending and enable registers for every set.
// Pending bits latch on pulses and clear on write-one-to-clear strobes; a
// pulse wins over a clear in the same cycle. Source 0 can never latch.
// Assumes pulses are already synchronized to clk.
module icu_status_bank #(
    parameter int N_SETS = 6,
    parameter int SET_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SETS*SET_W-1:0] src_pulse,
    input  logic [N_SETS-1:0]       clr_we,
    input  logic [N_SETS-1:0]       en_we,
    input  logic [SET_W-1:0]        wr_data,
    output logic [N_SETS*SET_W-1:0] pend_flat,
    output logic [N_SETS*SET_W-1:0] en_flat
);
    for (genvar s = 0; s < N_SETS; s++) begin : g_set
        logic [SET_W-1:0] pend_q;
        logic [SET_W-1:0] en_q;
        logic [SET_W-1:0] valid_m;
        logic [SET_W-1:0] clr_m;

        // Source 0 is invalid; every other bit may latch.
        if (s == 0) begin : g_first
            assign valid_m = {{(SET_W-1){1'b1}}, 1'b0};
        end else begin : g_rest
            assign valid_m = '1;
        end

        // Clear mask applies only when this set's clear word is written.
        assign clr_m = clr_we[s] ? wr_data : '0;

        // Latch pulses, drop cleared bits, pulse takes precedence.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= '0;
            end else begin
                pend_q <= (pend_q & ~clr_m) | (src_pulse[s*SET_W +: SET_W] & valid_m);
            end
        end

        // Enable register of this set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= '0;
            end else if (en_we[s]) begin
                en_q <= wr_data;
            end
        end

        assign pend_flat[s*SET_W +: SET_W] = pend_q;
        assign en_flat[s*SET_W +: SET_W]   = en_q;
    end
endmodule

// File: rtl/icu_level_router.sv
// Module: routes every pending bit either to its urgency level or to the
// flat low path, using the fixed table of the package. Purely combinational.
module icu_level_router #(
    parameter int N_SETS = 6,
    parameter int SET_W  = 32
) (
    input  logic [N_SETS*SET_W-1:0]   pend_flat,
    input  logic [N_SETS*SET_W-1:0]   en_flat,
    output logic [icu_pkg::NUM_LVL-1:0] lvl_pend,
    output logic                      low_pend
);
    import icu_pkg::*;

    // Per-line level table expanded once at elaboration.
    logic [LVL_W-1:0] lvl_tab [N_SETS*SET_W];
    for (genvar s = 0; s < N_SETS; s++) begin : g_s
        for (genvar b = 0; b < SET_W; b++) begin : g_b
            assign lvl_tab[s*SET_W+b] = level_of(s, b);
        end
    end

    // OR pending bits into their level, or into the enabled low group.
    always_comb begin
        lvl_pend = '0;
        low_pend = 1'b0;
        for (int i = 0; i < N_SETS*SET_W; i++) begin
            if (lvl_tab[i] != '0) begin
                lvl_pend[lvl_tab[i]] = lvl_pend[lvl_tab[i]] | pend_flat[i];
            end else begin
                low_pend = low_pend | (pend_flat[i] & en_flat[i]);
            end
        end
    end
endmodule

// File: rtl/icu_prio_encoder.sv
// Module: picks the highest set bit of a level vector; bit 0 is never a
// valid level and yields vector 0. Purely combinational.
module icu_prio_encoder #(
    parameter int NUM_LVL = 16,
    localparam int VEC_W  = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] lvl_req,
    output logic [VEC_W-1:0]   vec,
    output logic               any
);
    // Scan upward so the highest requesting level is the last one kept.
    always_comb begin
        vec = '0;
        for (int i = 1; i < NUM_LVL; i++) begin
            if (lvl_req[i]) vec = VEC_W'(i);
        end
    end

    assign any = |lvl_req[NUM_LVL-1:1];
endmodule

// File: rtl/icu_two_level.sv
// Module: top of the two-level interrupt controller. Holds the control
// word, decodes the register bus and forms both interrupt lines.
// Assumes a single-cycle bus: reads combinational, writes on the edge.
module icu_two_level #(
    parameter int N_SETS = 6,
    parameter int SET_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SETS*SET_W-1:0] src_pulse,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [SET_W-1:0]        bus_wdata,
    output logic [SET_W-1:0]        bus_rdata,
    output logic                    irq_high,
    output logic                    irq_low
);
    import icu_pkg::*;

    localparam int IDX_W = 3;
    localparam logic [ADDR_W-IDX_W-1:0] RG_PEND = 0;
    localparam logic [ADDR_W-IDX_W-1:0] RG_CLR  = 1;
    localparam logic [ADDR_W-IDX_W-1:0] RG_EN   = 2;
    localparam logic [ADDR_W-IDX_W-1:0] RG_MISC = 3;
    localparam logic [IDX_W-1:0] IX_CTL  = 0;
    localparam logic [IDX_W-1:0] IX_SUMM = 1;
    localparam int GE_BIT = NUM_LVL;

    logic [ADDR_W-IDX_W-1:0] region;
    logic [IDX_W-1:0]        idx;
    logic [N_SETS-1:0]       clr_we, en_we;
    logic [N_SETS*SET_W-1:0] pend_flat, en_flat;
    logic [NUM_LVL-1:0]      ctl_mask;
    logic                    ctl_ge;
    logic [NUM_LVL-1:0]      lvl_pend;
    logic                    low_pend;
    logic [LVL_W-1:0]        vec;
    logic                    high_pend;

    assign region = bus_addr[ADDR_W-1:IDX_W];
    assign idx    = bus_addr[IDX_W-1:0];

    // Per-set write strobes for the clear and enable words.
    always_comb begin
        clr_we = '0;
        en_we  = '0;
        for (int s = 0; s < N_SETS; s++) begin
            if (bus_wr && idx == IDX_W'(s)) begin
                clr_we[s] = (region == RG_CLR);
                en_we[s]  = (region == RG_EN);
            end
        end
    end

    // Control word: level mask and master enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_mask <= '0;
            ctl_ge   <= 1'b0;
        end else if (bus_wr && region == RG_MISC && idx == IX_CTL) begin
            ctl_mask <= bus_wdata[NUM_LVL-1:0];
            ctl_ge   <= bus_wdata[GE_BIT];
        end
    end

    icu_status_bank #(.N_SETS(N_SETS), .SET_W(SET_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .clr_we    (clr_we),
        .en_we     (en_we),
        .wr_data   (bus_wdata),
        .pend_flat (pend_flat),
        .en_flat   (en_flat)
    );

    icu_level_router #(.N_SETS(N_SETS), .SET_W(SET_W)) u_route (
        .pend_flat (pend_flat),
        .en_flat   (en_flat),
        .lvl_pend  (lvl_pend),
        .low_pend  (low_pend)
    );

    icu_prio_encoder #(.NUM_LVL(NUM_LVL)) u_enc (
        .lvl_req (lvl_pend & ctl_mask),
        .vec     (vec),
        .any     (high_pend)
    );

    // Both lines gated by the master enable.
    assign irq_high = ctl_ge & high_pend;
    assign irq_low  = ctl_ge & low_pend;

    // Combinational read mux over the register map.
    always_comb begin
        bus_rdata = '0;
        case (region)
            RG_PEND: if (int'(idx) < N_SETS) bus_rdata = pend_flat[int'(idx)*SET_W +: SET_W];
            RG_EN:   if (int'(idx) < N_SETS) bus_rdata = en_flat[int'(idx)*SET_W +: SET_W];
            RG_MISC: begin
                if (idx == IX_CTL) begin
                    bus_rdata[NUM_LVL-1:0] = ctl_mask;
                    bus_rdata[GE_BIT]      = ctl_ge;
                end else if (idx == IX_SUMM) begin
                    bus_rdata[LVL_W-1:0] = vec;
                    bus_rdata[8]         = high_pend;
                    bus_rdata[9]         = low_pend;
                end
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/icu_checker.sv
// Module: temporal properties of the controller, bound to the top.
module icu_checker #(
    parameter int N_SETS = 6,
    parameter int SET_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_SETS*SET_W-1:0] src_pulse,
    input logic                    bus_wr,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [SET_W-1:0]        bus_wdata,
    input logic [N_SETS*SET_W-1:0] pend_flat,
    input logic                    ctl_ge,
    input logic [3:0]              vec,
    input logic                    high_pend,
    input logic                    irq_high,
    input logic                    irq_low
);
    logic [N_SETS*SET_W-1:0] keep, arrive;

    // Bits expected to survive the edge, and bits a pulse must set.
    always_comb begin
        keep   = pend_flat;
        arrive = src_pulse;
        arrive[0] = 1'b0;
        for (int s = 0; s < N_SETS; s++) begin
            if (bus_wr && bus_addr == ADDR_W'(8 + s))
                keep[s*SET_W +: SET_W] = pend_flat[s*SET_W +: SET_W] & ~bus_wdata;
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_flat & $past(keep)) == $past(keep)));
    assert_pulse_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_flat & $past(arrive)) == $past(arrive)));
    assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_high || irq_low) |-> ctl_ge);
    assert_vec_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec != 4'd0) |-> high_pend);
    assert_high_has_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_high |-> (vec != 4'd0));
    assert_src0_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_flat[0]);
    assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_high && !irq_low && pend_flat == '0));
endmodule

bind icu_two_level icu_checker #(.N_SETS(N_SETS), .SET_W(SET_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend_flat (pend_flat),
    .ctl_ge    (ctl_ge),
    .vec       (vec),
    .high_pend (high_pend),
    .irq_high  (irq_high),
    .irq_low   (irq_low)
);

// File: tb/test_icu_two_level.sv
module test_icu_two_level;
    localparam int N_SETS = 6;
    localparam int SET_W  = 32;
    localparam int NL     = N_SETS*SET_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   src_pulse = '0;
    logic            bus_wr = 1'b0;
    logic [4:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_high, irq_low;
    int              checks = 0;
    int              errors = 0;

    always #4 clk = ~clk;

    icu_two_level i_icu_two_level (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_high(irq_high), .irq_low(irq_low)
    );

    // Vector table: {line[7:0], vector[3:0], high flag, low flag}
    localparam int NV = 13;
    localparam logic [13:0] TBL [NV] = '{
        {8'd185, 4'd15, 1'b1, 1'b0}, {8'd184, 4'd15, 1'b1, 1'b0},
        {8'd190, 4'd14, 1'b1, 1'b0}, {8'd189, 4'd13, 1'b1, 1'b0},
        {8'd50,  4'd4,  1'b1, 1'b0}, {8'd49,  4'd3,  1'b1, 1'b0},
        {8'd59,  4'd2,  1'b1, 1'b0}, {8'd167, 4'd1,  1'b1, 1'b0},
        {8'd160, 4'd1,  1'b1, 1'b0}, {8'd33,  4'd0,  1'b0, 1'b1},
        {8'd100, 4'd0,  1'b0, 1'b1}, {8'd5,   4'd0,  1'b0, 1'b1},
        {8'd0,   4'd0,  1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        src_pulse[line] = 1'b1;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic clr_line(input int line);
        wr(5'(8 + line/32), 32'(1) << (line % 32));
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(5'h18, d); chk("R1 ctl", d, 32'h0);
        for (int s = 0; s < N_SETS; s++) begin
            rd(5'(s), d); chk("R1 pend", d, 32'h0);
            rd(5'(16 + s), d); chk("R1 en", d, 32'h0);
        end
        chk("R1 lines", {30'b0, irq_high, irq_low}, 32'h0);

        // Setup for table: all enables, all levels, master enable
        for (int s = 0; s < N_SETS; s++) wr(5'(16 + s), 32'hFFFF_FFFF);
        wr(5'h18, 32'h0001_FFFF);
        rd(5'h18, d); chk("R12 ctl readback", d, 32'h0001_FFFF);

        // R8/R7/R9/R11: table walk
        for (int i = 0; i < NV; i++) begin
            int line;
            line = int'(TBL[i][13:6]);
            pulse(line);
            rd(5'h19, d);
            chk("R8 vector", {28'b0, d[3:0]}, {28'b0, TBL[i][5:2]});
            chk("R9 flags", {30'b0, d[9], d[8]}, {30'b0, TBL[i][0], TBL[i][1]});
            chk("R10 lines", {30'b0, irq_high, irq_low}, {30'b0, TBL[i][1], TBL[i][0]});
            rd(5'(line/32), d);
            chk("R11 latch", {31'b0, d[line%32]}, {31'b0, (line != 0)});
            clr_line(line);
            rd(5'(line/32), d); chk("R3 cleared", d, 32'h0);
        end

        // R2: holds with no further pulses
        pulse(33);
        repeat (4) @(negedge clk);
        rd(5'h01, d); chk("R2 hold", d, 32'h0000_0002);

        // R3: zeros leave bits alone
        pulse(34);
        wr(5'h09, 32'h0000_0002);
        rd(5'h01, d); chk("R3 partial clear", d, 32'h0000_0004);
        rd(5'h09, d); chk("R12 clear reads 0", d, 32'h0);
        // R3: pulse in same cycle as clear wins
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'h09; bus_wdata = 32'h0000_0004; src_pulse[34] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; src_pulse = '0;
        rd(5'h01, d); chk("R3 pulse wins", d, 32'h0000_0004);
        clr_line(34);

        // R6/R7: mask gating, tie, highest
        wr(5'h18, 32'h0001_0002);
        pulse(189);
        rd(5'h19, d); chk("R6 masked vec", {28'b0, d[3:0]}, 32'h0);
        chk("R6 masked line", {31'b0, irq_high}, 32'h0);
        pulse(160);
        pulse(167);
        rd(5'h19, d); chk("R7 tie vec", {28'b0, d[3:0]}, 32'h1);
        chk("R6 level1 line", {31'b0, irq_high}, 32'h1);
        wr(5'h18, 32'h0001_FFFF);
        rd(5'h19, d); chk("R7 highest", {28'b0, d[3:0]}, 32'hD);

        // R10/R9: master enable off keeps lines low, flags remain
        pulse(100);
        wr(5'h18, 32'h0000_FFFF);
        chk("R10 off", {30'b0, irq_high, irq_low}, 32'h0);
        rd(5'h19, d); chk("R9 flags ungated", {30'b0, d[9], d[8]}, 32'h3);
        clr_line(100); clr_line(189); clr_line(160); clr_line(167);

        // R5: urgent source with its enable bit set does not drive low line
        wr(5'h18, 32'h0001_0000);
        pulse(185);
        chk("R5 low untouched", {30'b0, irq_high, irq_low}, 32'h0);
        rd(5'h19, d); chk("R5 low flag", {31'b0, d[9]}, 32'h0);
        clr_line(185);

        // R4: enable bit controls low line
        wr(5'h13, 32'h0);
        pulse(100);
        chk("R4 disabled", {31'b0, irq_low}, 32'h0);
        wr(5'h13, 32'h0000_0010);
        chk("R4 enabled", {31'b0, irq_low}, 32'h1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule